// File: doc/BRIEF.md
# Compare/Capture/PWM Channel

One channel of a multi-channel timer array. It watches a free-running 16-bit counter that is shared by all channels and owns one 16-bit compare/capture register. A per-channel mode byte decides what the channel does with that register. It can raise an event when the counter reaches the register value. It can invert its output pin on each such match. It can generate an 8-bit pulse-width-modulated waveform. It can also snapshot the counter when a chosen edge arrives on its input pin.

Software programs the channel through a byte-wide write port with three locations: the mode byte, the low byte of the register and the high byte of the register. The channel reports to the array's common flag register through a one-cycle event strobe. It also tells the array whether its flag may raise an interrupt. The register contents are always visible on a read-back bus.

Top module: `cmpcap_channel`

## Requirements
- R1: After reset, pinOut is 0, evtStrobe is 0, evtIrqEn is 0 and capVal is 0x0000.
- R2: A write with wrAddr=1 loads wrData into capVal[7:0], and a write with wrAddr=2 loads wrData into capVal[15:8]. Each becomes visible after the clock edge that takes the write. A software write takes precedence over a capture or a reload in the same cycle.
- R3: Writing wrAddr=0 loads the mode byte, and evtIrqEn follows its bit 0 from the next cycle.
- R4: With mode bits 6 (comparator enable) and 3 (flag on match) set and bit 1 clear, a cycle in which cntRun is high and cntVal equals capVal makes evtStrobe high for exactly the next cycle. It does not stay high while the equality persists.
- R5: No match event occurs while mode bit 6 is clear or while cntRun is low.
- R6: With mode bits 6 and 2 (toggle) set and bit 1 clear, every match inverts pinOut one cycle later. Without bit 3 set, a match raises no evtStrobe.
- R7: With mode bit 1 (PWM) set, pinOut is 0 in the cycle after one where cntVal[7:0] < capVal[7:0], and 1 otherwise. Match events raise neither a toggle nor a strobe in this mode.
- R8: In PWM mode, a cycle with cntRun high and cntVal[7:0] = 0xFF copies capVal[15:8] into capVal[7:0]. No copy happens while cntRun is low.
- R9: Mode bit 5 selects capture on a rising edge of pinIn, and mode bit 4 selects capture on a falling edge. On a selected edge, the full cntVal is latched into capVal and evtStrobe pulses, both visible after the third rising clock edge following the pin change. An edge that is not selected changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cntVal | input | 16 | Shared counter value |
| cntRun | input | 1 | High when the shared counter advances this cycle |
| pinIn | input | 1 | External capture input, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 mode byte, 1 register low byte, 2 register high byte |
| wrData | input | 8 | Write data |
| pinOut | output | 1 | External channel output |
| evtStrobe | output | 1 | One-cycle event to the shared flag register |
| evtIrqEn | output | 1 | Flag may request an interrupt (mode bit 0) |
| capVal | output | 16 | Compare/capture register contents |

## Verification
Every cycle, the assertions check four things. A strobe that is not caused by a capture must trace back to a running counter with the comparator enabled. Outside PWM mode, pinOut may change only after a toggle-enabled match. In PWM mode, pinOut must agree with the previous cycle's low-byte comparison. Captures and reloads must move exactly the right bits into the register. Other properties need directed scenarios in the bench: the single-cycle strobe under a stalled but running counter, the exact three-edge capture latency, rejection of the unselected edge, and reload suppression while the counter is stopped.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

  // Mode byte, bit 6 down to bit 0.
  typedef struct packed {
    logic ecom;     // bit 6: comparator enable
    logic capPos;   // bit 5: capture on rising input edge
    logic capNeg;   // bit 4: capture on falling input edge
    logic matFlag;  // bit 3: match raises event strobe
    logic togl;     // bit 2: match inverts output
    logic pwm;      // bit 1: pulse-width mode
    logic irqEn;    // bit 0: flag may request interrupt
  } modeT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic match;
    logic reload;
    logic pwmBelow;
  } strobeT;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

endpackage

// File: rtl/cmpcap_ctrl.sv
module cmpcap_ctrl
  import cmpcap_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntRun,
  input  logic             pinIn,
  input  logic             ecom,
  input  logic             capPos,
  input  logic             capNeg,
  input  logic             pwmOn,
  input  logic [CNT_W-1:0] ccQ,
  output strobeT           strb
);

  // Synchronizer stages plus one history bit for edge detection.
  logic [SYNC_STAGES:0] syncQ;
  logic                 hitPrev;
  logic                 hit;
  logic                 pinNow;
  logic                 pinOld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      hitPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-1:0], pinIn};
      hitPrev <= hit;
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];
  assign pinOld = syncQ[SYNC_STAGES];
  assign hit    = cntRun & ecom & (cntVal == ccQ);

  always_comb begin
    strb          = '0;
    strb.capture  = (capPos & pinNow & ~pinOld) | (capNeg & ~pinNow & pinOld);
    strb.match    = hit & ~hitPrev;
    strb.reload   = pwmOn & cntRun & (&cntVal[BYTE_W-1:0]);
    strb.pwmBelow = cntVal[BYTE_W-1:0] < ccQ[BYTE_W-1:0];
  end

endmodule

// File: rtl/cmpcap_dpath.sv
module cmpcap_dpath
  import cmpcap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  strobeT            strb,
  output modeT              modeQ,
  output logic [CNT_W-1:0]  ccQ,
  output logic              pinOut,
  output logic              evtStrobe
);

  localparam int MODE_W = $bits(modeT);

  logic wrMode;
  logic wrLo;
  logic wrHi;

  assign wrMode = wrEn & (wrAddr == ADDR_MODE);
  assign wrLo   = wrEn & (wrAddr == ADDR_LO);
  assign wrHi   = wrEn & (wrAddr == ADDR_HI);

  // Mode byte
  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= '0;
    else if (wrMode) modeQ <= modeT'(wrData[MODE_W-1:0]);
  end

  // Compare/capture register: software write first, then capture, then reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccQ <= '0;
    end else if (wrLo) begin
      ccQ[BYTE_W-1:0] <= wrData;
    end else if (wrHi) begin
      ccQ[CNT_W-1:BYTE_W] <= wrData;
    end else if (strb.capture) begin
      ccQ <= cntVal;
    end else if (strb.reload) begin
      ccQ[BYTE_W-1:0] <= ccQ[CNT_W-1:BYTE_W];
    end
  end

  // Output pin and event strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut    <= 1'b0;
      evtStrobe <= 1'b0;
    end else begin
      evtStrobe <= strb.capture | (strb.match & modeQ.matFlag & ~modeQ.pwm);
      if (modeQ.pwm)                     pinOut <= ~strb.pwmBelow;
      else if (strb.match & modeQ.togl)  pinOut <= ~pinOut;
    end
  end

endmodule

// File: rtl/cmpcap_channel.sv
module cmpcap_channel
  import cmpcap_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntRun,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic              pinOut,
  output logic              evtStrobe,
  output logic              evtIrqEn,
  output logic [CNT_W-1:0]  capVal
);

  modeT             modeQ;
  strobeT           strb;
  logic [CNT_W-1:0] ccQ;

  cmpcap_ctrl #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cntVal (cntVal),
    .cntRun (cntRun),
    .pinIn  (pinIn),
    .ecom   (modeQ.ecom),
    .capPos (modeQ.capPos),
    .capNeg (modeQ.capNeg),
    .pwmOn  (modeQ.pwm),
    .ccQ    (ccQ),
    .strb   (strb)
  );

  cmpcap_dpath #(.BYTE_W(BYTE_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .cntVal    (cntVal),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strb      (strb),
    .modeQ     (modeQ),
    .ccQ       (ccQ),
    .pinOut    (pinOut),
    .evtStrobe (evtStrobe)
  );

  assign evtIrqEn = modeQ.irqEn;
  assign capVal   = ccQ;

endmodule

// File: rtl/cmpcap_channel_chk.sv
module cmpcap_channel_chk
  import cmpcap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic             cntRun,
  input logic             wrEn,
  input logic             ecom,
  input logic             pwmOn,
  input logic             togl,
  input strobeT           strb,
  input logic             pinOut,
  input logic             evtStrobe,
  input logic [CNT_W-1:0] capVal
);

  // R5: a strobe not caused by capture needs a running counter and an enabled comparator
  a_r5_match_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (evtStrobe && !$past(strb.capture)) |-> $past(cntRun && ecom));

  // R6: outside PWM mode the pin changes only after a toggle-enabled match
  a_r6_pin_change_src: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pwmOn) && (pinOut != $past(pinOut))) |-> $past(strb.match && togl));

  // R7: in PWM mode the pin reflects the previous low-byte comparison
  a_r7_pwm_level: assert property (@(posedge clk) disable iff (!rstN)
    $past(pwmOn) |-> (pinOut == !$past(strb.pwmBelow)));

  // R9: a capture latches the counter and pulses the strobe
  a_r9_capture_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capture) && !$past(wrEn)) |-> ((capVal == $past(cntVal)) && evtStrobe));

  // R8: a reload copies the high byte into the low byte
  a_r8_reload_copy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.reload) && !$past(strb.capture) && !$past(wrEn))
      |-> (capVal[BYTE_W-1:0] == $past(capVal[CNT_W-1:BYTE_W])));

endmodule

bind cmpcap_channel cmpcap_channel_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cntVal    (cntVal),
  .cntRun    (cntRun),
  .wrEn      (wrEn),
  .ecom      (modeQ.ecom),
  .pwmOn     (modeQ.pwm),
  .togl      (modeQ.togl),
  .strb      (strb),
  .pinOut    (pinOut),
  .evtStrobe (evtStrobe),
  .capVal    (capVal)
);

// File: tb/cmpcap_channel_tb_top.sv
`timescale 1ns/1ps
module cmpcap_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic        cntRun = 1'b0;
  logic        pinIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        pinOut;
  logic        evtStrobe;
  logic        evtIrqEn;
  logic [15:0] capVal;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  cmpcap_channel dut_i (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntRun(cntRun), .pinIn(pinIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinOut(pinOut), .evtStrobe(evtStrobe), .evtIrqEn(evtIrqEn), .capVal(capVal)
  );

  // Expected outputs after one clock edge; -1 means not checked.
  typedef struct {
    string req;
    int    ev;
    int    pn;
    int    cv;
    int    ir;
  } expT;

  expT sbQ[$];

  task automatic cmpOne(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per clock edge, samples after the edge.
  always @(posedge clk) begin
    #1;
    if (sbQ.size() > 0) begin
      expT it;
      it = sbQ.pop_front();
      if (it.ev >= 0) cmpOne(it.req, "evtStrobe", int'(evtStrobe), it.ev);
      if (it.pn >= 0) cmpOne(it.req, "pinOut", int'(pinOut), it.pn);
      if (it.cv >= 0) cmpOne(it.req, "capVal", int'(capVal), it.cv);
      if (it.ir >= 0) cmpOne(it.req, "evtIrqEn", int'(evtIrqEn), it.ir);
    end
  end

  // Driver: inputs are already set; push the expectation and run one cycle.
  task automatic step(input string req, input int ev, input int pn, input int cv, input int ir);
    expT it;
    it.req = req; it.ev = ev; it.pn = pn; it.cv = cv; it.ir = ir;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req,
                    input int ev, input int pn, input int cv, input int ir);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(req, ev, pn, cv, ir);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    step("R1", 0, 0, 'h0000, 0);

    // R2: byte writes
    wr(2'd1, 8'h34, "R2", 0, -1, 'h0034, -1);
    wr(2'd2, 8'h12, "R2", 0, -1, 'h1234, -1);

    // R3: mode bit 0 drives evtIrqEn; mode 0x49 = ecom, flag, irq
    wr(2'd0, 8'h49, "R3", 0, 0, 'h1234, 1);

    // R4: single-cycle match strobe
    cntRun = 1'b1;
    cntVal = 16'h1233; step("R4", 0, -1, -1, -1);
    cntVal = 16'h1234; step("R4", 1, 0, -1, -1);
    step("R4", 0, -1, -1, -1);  // equality persists, no second strobe
    cntVal = 16'h1235; step("R4", 0, -1, -1, -1);

    // R5: stopped counter and disabled comparator give no match
    cntRun = 1'b0;
    cntVal = 16'h1233; step("R5", 0, -1, -1, -1);
    cntVal = 16'h1234; step("R5", 0, -1, -1, -1);
    cntRun = 1'b1;
    cntVal = 16'h1233;
    wr(2'd0, 8'h09, "R5", 0, -1, -1, 1);
    cntVal = 16'h1234; step("R5", 0, -1, -1, 1);
    cntVal = 16'h1235; step("R5", 0, -1, -1, -1);

    // R6: toggle on match, no strobe without flag bit; mode 0x44
    cntVal = 16'h1233;
    wr(2'd0, 8'h44, "R3", 0, 0, -1, 0);
    cntVal = 16'h1234; step("R6", 0, 1, -1, -1);
    cntVal = 16'h1235; step("R6", 0, 1, -1, -1);
    cntVal = 16'h1234; step("R6", 0, 0, -1, -1);
    cntVal = 16'h1236; step("R6", 0, 0, -1, -1);

    // R7: PWM level, compare register 0x8040, mode 0x42
    cntVal = 16'h0000;
    wr(2'd1, 8'h40, "R2", 0, -1, 'h1240, -1);
    wr(2'd2, 8'h80, "R2", 0, -1, 'h8040, -1);
    wr(2'd0, 8'h42, "R7", 0, 0, 'h8040, 0);
    cntVal = 16'h0010; step("R7", 0, 0, -1, -1);
    cntVal = 16'h0040; step("R7", 0, 1, -1, -1);
    cntVal = 16'h00C0; step("R7", 0, 1, -1, -1);
    cntVal = 16'h003F; step("R7", 0, 0, -1, -1);
    cntVal = 16'h8040; step("R7", 0, 1, 'h8040, -1);  // match suppressed

    // R8: reload of low byte at low-byte wrap
    cntVal = 16'h00FF; step("R8", 0, 1, 'h8080, -1);
    cntVal = 16'h0050; step("R8", 0, 0, 'h8080, -1);
    cntVal = 16'h0090; step("R8", 0, 1, -1, -1);
    wr(2'd2, 8'h20, "R2", 0, -1, 'h2080, -1);
    cntRun = 1'b0;
    cntVal = 16'h01FF; step("R8", 0, 1, 'h2080, -1);
    cntRun = 1'b1;
    step("R8", 0, 1, 'h2020, -1);

    // R9: rising-edge capture, mode 0x20
    cntRun = 1'b0;
    cntVal = 16'hABCD;
    wr(2'd0, 8'h20, "R9", 0, -1, 'h2020, 0);
    pinIn = 1'b1;
    step("R9", 0, -1, 'h2020, -1);
    step("R9", 0, -1, 'h2020, -1);
    step("R9", 1, -1, 'hABCD, -1);
    step("R9", 0, -1, 'hABCD, -1);
    // falling edge not selected
    cntVal = 16'h1111;
    pinIn = 1'b0;
    for (int i = 0; i < 4; i++) step("R9", 0, -1, 'hABCD, -1);

    // R9: falling-edge capture, mode 0x10
    cntVal = 16'h5A5A;
    wr(2'd0, 8'h10, "R9", 0, -1, 'hABCD, -1);
    pinIn = 1'b1;
    for (int i = 0; i < 4; i++) step("R9", 0, -1, 'hABCD, -1);
    pinIn = 1'b0;
    step("R9", 0, -1, 'hABCD, -1);
    step("R9", 0, -1, 'hABCD, -1);
    step("R9", 1, -1, 'h5A5A, -1);
    step("R9", 0, -1, 'h5A5A, -1);

    @(negedge clk);
    finishRun();
  end

endmodule